// File: doc/BRIEF.md
# Two-Wire Configuration Write Slave

This block is the write-only control port of a register bank. It watches the two bus lines, SCL and SDA, which have already been brought into the system clock domain. It recognises start, repeated-start and stop conditions and compares the first byte of a transfer against a fixed device address.

After a matching address, the first byte is a subaddress. Its low nibble names a target register and one bit selects between two modes. In the first mode every data byte rewrites the same register. In the second mode the register index advances by one for each byte.

Every accepted data byte leaves the block as a single-cycle write strobe, together with a 3-bit register index and the 8-bit value. The open-drain pad is outside the block. The block only says when the line must be pulled low, through `sdaOe`.

Top module: `cfg_i2c_wr_slave`

## Requirements
- R1: SDA falling while SCL is high (a start) begins address matching. SDA rising while SCL is high (a stop) returns the slave to idle. Bytes clocked after a stop get no acknowledge and no write until the next start.
- R2: Only the address byte 0x88 (7-bit address 1000100, write bit 0) is acknowledged. Any other first byte, including 0x89, is not acknowledged, and the slave ignores the bus until the next start.
- R3: Bytes are 8 bits, sampled on SCL rising edges, most significant bit first. `sdaOe` rises after the SCL falling edge that ends the 8th bit and falls after the falling edge that ends the 9th clock. It never changes while SCL stays high and is low during the 8 data bits.
- R4: The byte after a matched address is the subaddress and is always acknowledged. Bits 3..0 give the register index, bit 4 is the increment flag, and bits 7..5 have no effect.
- R5: With the increment flag 0, every data byte up to the stop or repeated start is written to the subaddress index.
- R6: With the increment flag 1, the first data byte goes to the subaddress index and each following byte goes to the previous index plus one. The low three index bits wrap from 7 to 0.
- R7: A data byte whose index has bit 3 set (8 to 15) is acknowledged but produces no write strobe. In increment mode the index stays in 8..15, wrapping 15 to 8.
- R8: Each written byte produces `wrStrobe` high for exactly one system clock while the acknowledge is driven. `wrIndex` and `wrData` carry the index and the received byte in that cycle.
- R9: A repeated start anywhere in a transfer, including in the middle of a byte, abandons that transfer without a write and restarts address matching.
- R10: After reset `sdaOe` and `wrStrobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronised bus clock level |
| sdaIn | input | 1 | Synchronised bus data level |
| sdaOe | output | 1 | 1 = pull the data line low (acknowledge) |
| wrStrobe | output | 1 | One-cycle register write pulse |
| wrIndex | output | 3 | Register index of the write |
| wrData | output | 8 | Byte value of the write |

## Verification
The bench goes after the index corner cases. It wraps increment mode from index 7 to 0; a design that carried into bit 3 would stop writing after index 7. It starts a burst at index 15; a design that let the index roll over into 0..7 would write registers it must not touch. It also sends a wrong address and the read form of the right one; a slave that acknowledged either would accept foreign traffic. A repeated start cut into the middle of a byte checks that no partial byte is written, and clocking bytes after a stop checks that the slave really went idle. The bench also checks that the acknowledge begins and ends on the right SCL falling edges; a slave one edge off would either hold the line through a data bit or miss the ninth clock.

// File: rtl/cfg_i2c_wr_pkg.sv
package cfg_i2c_wr_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_SUB, PH_DATA} phase_e;

  // Bus events seen by the datapath
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic sclRise;
    logic sclFall;
  } bus_evt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadSub;
    logic stepIdx;
    logic emitWr;
  } dp_cmd_t;
endpackage

// File: rtl/cfg_i2c_wr_dp.sv
module cfg_i2c_wr_dp
  import cfg_i2c_wr_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h88,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  dp_cmd_t          cmd,
  output bus_evt_t         evt,
  output logic             addrHit,
  output logic             wrStrobe,
  output logic [IDX_W-1:0] wrIndex,
  output logic [7:0]       wrData
);
  localparam int SUB_W   = IDX_W + 1;  // index plus out-of-bank bit
  localparam int INC_POS = IDX_W + 1;  // increment flag position

  logic                 sclPrev, sdaPrev;
  logic [BYTE_BITS-1:0] shiftReg;
  logic [SUB_W-1:0]     curIdx;
  logic                 incMode;

  always_comb begin
    evt.sclRise   = sclIn & ~sclPrev;
    evt.sclFall   = ~sclIn & sclPrev;
    evt.startSeen = sclIn & sclPrev & sdaPrev & ~sdaIn;
    evt.stopSeen  = sclIn & sclPrev & ~sdaPrev & sdaIn;
  end

  assign addrHit = (shiftReg == DEV_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
      shiftReg <= '0;
      curIdx   <= '0;
      incMode  <= 1'b0;
      wrStrobe <= 1'b0;
      wrIndex  <= '0;
      wrData   <= '0;
    end else begin
      sclPrev  <= sclIn;
      sdaPrev  <= sdaIn;
      wrStrobe <= cmd.emitWr & ~curIdx[IDX_W];
      if (cmd.shiftIn)
        shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaIn};
      if (cmd.loadSub) begin
        curIdx  <= shiftReg[SUB_W-1:0];
        incMode <= shiftReg[INC_POS];
      end
      if (cmd.stepIdx && incMode)
        curIdx <= {curIdx[IDX_W], curIdx[IDX_W-1:0] + 1'b1};
      if (cmd.emitWr) begin
        wrIndex <= curIdx[IDX_W-1:0];
        wrData  <= shiftReg;
      end
    end
  end
endmodule

// File: rtl/cfg_i2c_wr_ctrl.sv
module cfg_i2c_wr_ctrl
  import cfg_i2c_wr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  bus_evt_t evt,
  input  logic     addrHit,
  output dp_cmd_t  cmd,
  output logic     sdaOe
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

  phase_e           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             ackOn;
  logic             busy, byteDone, ackEnd;

  assign busy     = (phase != PH_IDLE);
  assign byteDone = evt.sclFall && busy && !ackOn && (bitCnt == LAST_BIT);
  assign ackEnd   = evt.sclFall && ackOn;
  assign sdaOe    = ackOn;

  always_comb begin
    cmd.shiftIn = evt.sclRise && busy && !ackOn && (bitCnt < LAST_BIT);
    cmd.loadSub = byteDone && (phase == PH_SUB);
    cmd.emitWr  = byteDone && (phase == PH_DATA);
    cmd.stepIdx = ackEnd && (phase == PH_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (evt.startSeen) begin
      phase  <= PH_ADDR;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (evt.stopSeen) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else begin
      if (cmd.shiftIn)
        bitCnt <= bitCnt + 1'b1;
      if (byteDone) begin
        if (phase == PH_ADDR && !addrHit) phase <= PH_IDLE;
        else                              ackOn <= 1'b1;
      end
      if (ackEnd) begin
        ackOn  <= 1'b0;
        bitCnt <= '0;
        if (phase == PH_ADDR)     phase <= PH_SUB;
        else if (phase == PH_SUB) phase <= PH_DATA;
      end
    end
  end
endmodule

// File: rtl/cfg_i2c_wr_slave.sv
module cfg_i2c_wr_slave
  import cfg_i2c_wr_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h88,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  output logic             wrStrobe,
  output logic [IDX_W-1:0] wrIndex,
  output logic [7:0]       wrData
);
  bus_evt_t evt;
  dp_cmd_t  cmd;
  logic     addrHit;

  cfg_i2c_wr_dp #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .cmd(cmd),
    .evt(evt), .addrHit(addrHit), .wrStrobe(wrStrobe),
    .wrIndex(wrIndex), .wrData(wrData)
  );

  cfg_i2c_wr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .evt(evt), .addrHit(addrHit),
    .cmd(cmd), .sdaOe(sdaOe)
  );
endmodule

// File: rtl/cfg_i2c_wr_chk.sv
module cfg_i2c_wr_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic sdaOe,
  input logic wrStrobe
);
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn); // R3
  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclIn); // R3
  AST_OE_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaOe)); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R8
  AST_STROBE_IN_ACK: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> sdaOe); // R8
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && sdaIn && !$past(sdaIn)) |=> !sdaOe); // R1
endmodule

bind cfg_i2c_wr_slave cfg_i2c_wr_chk uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaOe(sdaOe), .wrStrobe(wrStrobe)
);

// File: tb/cfg_i2c_wr_slave_test.sv
module cfg_i2c_wr_slave_test;
  localparam int Q = 4; // system clocks per quarter bus period

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic       sdaBus;
  logic       sdaOe, wrStrobe;
  logic [2:0] wrIndex;
  logic [7:0] wrData;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  bit prevStrobe = 0;
  logic [10:0] expQ[$];
  string       expTag[$];

  always #4 clk = ~clk; // 125 MHz

  assign sdaBus = mSda & ~sdaOe; // wired-AND bus

  cfg_i2c_wr_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .wrStrobe(wrStrobe), .wrIndex(wrIndex), .wrData(wrData)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectWr(logic [2:0] idx, logic [7:0] val, string tag);
    expQ.push_back({idx, val});
    expTag.push_back(tag);
  endtask

  task automatic expectDrained(string tag);
    check(expQ.size() == 0, tag, expQ.size(), 0);
  endtask

  // Reference monitor: strobes compared against the expected queue every clock
  always @(negedge clk) begin
    if (rstN) begin
      if (wrStrobe) begin
        check(!prevStrobe, "R8 strobe longer than one cycle", 1, 0);
        if (expQ.size() == 0)
          check(1'b0, "R8 unexpected write strobe", {wrIndex, wrData}, 0);
        else begin
          logic [10:0] e;
          string t;
          e = expQ.pop_front();
          t = expTag.pop_front();
          check({wrIndex, wrData} == e, t, {wrIndex, wrData}, e);
        end
      end
      prevStrobe = wrStrobe;
    end
  end

  task automatic startCond();
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b0; tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic stopCond();
    mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b1; tick(Q);
  endtask

  task automatic sendBit(bit b);
    mSda = b; tick(Q);
    mScl = 1'b1; tick(Q);
    check(sdaOe == 1'b0, "R3 line driven during data bit", sdaOe, 0);
    tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic sendByte(logic [7:0] b, bit expAck, string tag);
    bit ackSeen;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    ackSeen = (sdaBus == 1'b0);
    tick(Q);
    mScl = 1'b0; tick(Q);
    check(ackSeen == expAck, tag, ackSeen, expAck);
  endtask

  initial begin
    begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
        nFail++;
        nChecks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
        $finish;
      end
    end
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(2);
    // R10 reset state
    check(sdaOe == 1'b0, "R10 sdaOe after reset", sdaOe, 0);
    check(wrStrobe == 1'b0, "R10 wrStrobe after reset", wrStrobe, 0);

    // R5 single-register mode, index 2
    startCond();
    sendByte(8'h88, 1, "R2 address ack");
    sendByte(8'h02, 1, "R4 subaddress ack");
    expectWr(3'd2, 8'hA5, "R5 first byte");
    sendByte(8'hA5, 1, "R8 data ack");
    expectDrained("R8 strobe during ack");
    expectWr(3'd2, 8'h3C, "R5 same index again");
    sendByte(8'h3C, 1, "R5 data ack");
    expectDrained("R5 strobe during ack");
    stopCond();

    // R6 increment mode with wrap 7->0, don't-care bits 7..5 set (R4)
    startCond();
    sendByte(8'h88, 1, "R2 address ack");
    sendByte(8'hF6, 1, "R4 subaddress ack");
    expectWr(3'd6, 8'h11, "R6 first index");
    sendByte(8'h11, 1, "R6 data ack");
    expectWr(3'd7, 8'h22, "R6 index plus one");
    sendByte(8'h22, 1, "R6 data ack");
    expectWr(3'd0, 8'h33, "R6 wrap to zero");
    sendByte(8'h33, 1, "R6 data ack");
    expectDrained("R6 all increments written");
    stopCond();

    // R2 wrong address and read form are ignored
    startCond();
    sendByte(8'h8A, 0, "R2 wrong address nack");
    sendByte(8'h02, 0, "R2 ignored after nack");
    sendByte(8'h55, 0, "R2 ignored data");
    stopCond();
    startCond();
    sendByte(8'h89, 0, "R2 read address nack");
    sendByte(8'h01, 0, "R2 ignored after read nack");
    stopCond();
    expectDrained("R2 no writes from foreign address");

    // R7 index with bit 3 set: acked, no strobe
    startCond();
    sendByte(8'h88, 1, "R2 address ack");
    sendByte(8'h0B, 1, "R4 subaddress ack");
    sendByte(8'h99, 1, "R7 out-of-bank data ack");
    stopCond();
    startCond();
    sendByte(8'h88, 1, "R2 address ack");
    sendByte(8'h1F, 1, "R4 subaddress ack");
    sendByte(8'h01, 1, "R7 index 15 ack");
    sendByte(8'h02, 1, "R7 wrapped to 8 ack");
    stopCond();
    expectDrained("R7 no strobe for index 8..15");

    // R9 repeated start mid-byte abandons partial byte
    startCond();
    sendByte(8'h88, 1, "R2 address ack");
    sendByte(8'h05, 1, "R4 subaddress ack");
    expectWr(3'd5, 8'h44, "R9 write before restart");
    sendByte(8'h44, 1, "R9 data ack");
    for (int i = 0; i < 4; i++) sendBit(i[0]);
    startCond();
    sendByte(8'h88, 1, "R9 address after restart");
    sendByte(8'h03, 1, "R9 subaddress after restart");
    expectWr(3'd3, 8'h7E, "R9 write after restart");
    sendByte(8'h7E, 1, "R9 data ack");
    expectDrained("R9 no partial write");
    stopCond();

    // R1 after stop, bytes are ignored until a start
    sendByte(8'h88, 0, "R1 address after stop nack");
    sendByte(8'h00, 0, "R1 byte after stop nack");
    sendByte(8'hFF, 0, "R1 byte after stop nack");
    mSda = 1'b1; tick(Q); mScl = 1'b1; tick(4 * Q);
    expectDrained("R1 no write while idle");
    check(sdaOe == 1'b0, "R1 idle line released", sdaOe, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule